// File: doc/BRIEF.md
# Machine-Check Error Reporting Bank

This block is one error-logging bank for a processor's machine-check path. Several hardware error detectors feed it through parallel event ports. Each event is either correctable or uncorrectable and carries:

- a 16-bit architectural error code;
- a 16-bit model-specific code;
- an optional physical address, with a flag saying whether that address can be trusted;
- a flag marking the event as coming from a speculative access.

The bank condenses these events into a 64-bit status word and an address register. It decides when a newer event may replace what is already logged. It raises a one-cycle machine-check pulse whenever an uncorrectable error is accepted.

Control is a four-state machine:

- CLEARING: entered on reset. Holds the bank at zero and ignores all inputs for a programmable number of cycles. Goes to EMPTY when that count ends.
- EMPTY: the first accepted event moves the bank to HOLD_CE or HOLD_UC according to its class.
- HOLD_CE: any accepted event overwrites the logged fields and sets overflow. A correctable event stays in HOLD_CE; an uncorrectable one moves the bank to HOLD_UC.
- HOLD_UC: fields are frozen. Further accepted events only set overflow.

From any state except CLEARING, a software write of zero to the status register returns the bank to EMPTY.

Status layout, bit positions fixed:

| Bits | Field |
|------|-------|
| 63 | valid |
| 62 | overflow |
| 61 | uncorrected |
| 58 | address valid |
| 31:16 | model-specific code |
| 15:0 | error code |

All other bits read zero.

Top module: `mcb_bank`

## Requirements
- R1: While `rst_n` is low, `stat_o`, `addr_o` and `mce_pulse_o` are zero. After release the bank stays in CLEARING for CLR_CYCLES clock edges and ignores events and software writes. Asserting reset again during CLEARING restarts the count, so the bank still comes up empty.
- R2: In EMPTY, an accepted event sets valid (bit 63). It copies its class to bit 61 (1 = uncorrectable), its error code to bits 15:0 and its model-specific code to bits 31:16. Every other status bit is zero.
- R3: Address valid (bit 58) and `addr_o` are written from an event only when its `evt_addr_ok` is 1. An event that overwrites the log with `evt_addr_ok` = 0 clears bit 58 and leaves `addr_o` unchanged.
- R4: An event with `evt_spec` = 1 and `evt_uc` = 0 is ignored completely. It does not touch status, address, overflow or the machine-check pulse.
- R5: Overflow (bit 62) becomes 1 when an accepted event arrives while valid is 1, whatever class is held.
- R6: With a correctable error held, a new correctable event overwrites all logged fields and sets overflow.
- R7: With an uncorrectable error held, later events change no logged field (error code, model-specific code, address valid, address). Only overflow may change.
- R8: A correctable event never replaces an uncorrectable one. An uncorrectable event replaces a held correctable one.
- R9: When several ports report in one cycle, the winner is the lowest-index uncorrectable port. If there is none, it is the lowest-index port. The losing events set overflow.
- R10: A software write of 64'h0 clears the whole status word and `addr_o` and returns the bank to EMPTY. A write of any nonzero value has no effect.
- R11: `mce_pulse_o` is 1 for one cycle, on the clock edge that logs an accepted uncorrectable event. It stays 0 for correctable events and for events that only set overflow.
- R12: A clearing write and an event in the same cycle log the event into the emptied bank, with overflow starting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_vld | input | NP | Event present, one bit per detector port |
| evt_uc | input | NP | Event class, 1 = uncorrectable |
| evt_spec | input | NP | Event came from a speculative access |
| evt_addr_ok | input | NP | Event address is trustworthy |
| evt_code | input | NP*16 | Error codes, port i at bits [16*i +: 16] |
| evt_ms | input | NP*16 | Model-specific codes, port i at bits [16*i +: 16] |
| evt_addr | input | NP*ADDR_W | Addresses, port i at bits [ADDR_W*i +: ADDR_W] |
| sw_we | input | 1 | Software write strobe to the status register |
| sw_wdata | input | 64 | Software write data |
| stat_o | output | 64 | Status word |
| addr_o | output | ADDR_W | Logged address |
| mce_pulse_o | output | 1 | Machine-check pulse |

## Verification
The bench builds the bank with NP = 3, ADDR_W = 40 and CLR_CYCLES = 6:

- Three ports let one cycle carry an uncorrectable event on the highest port together with correctable events on lower ports, which exercises both arms of the priority rule.
- A speculative correctable event can sit beside a real one, so the bench can show that it neither wins nor counts as a loser.
- The six-cycle clearing window is long enough to pulse reset again inside it and inject events there, and still confirm a clean empty bank afterwards.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    localparam int STAT_W   = 64;
    localparam int CODE_W   = 16;
    localparam int MS_W     = 16;

    localparam int B_VALID  = 63;
    localparam int B_OVF    = 62;
    localparam int B_UC     = 61;
    localparam int B_AV     = 58;
    localparam int B_MS_LSB = 16;
    localparam int B_CODE_LSB = 0;

    typedef enum logic [1:0] {
        ST_CLEARING = 2'd0,
        ST_EMPTY    = 2'd1,
        ST_HOLD_CE  = 2'd2,
        ST_HOLD_UC  = 2'd3
    } bank_state_e;

    typedef struct packed {
        logic              uc;
        logic              addr_ok;
        logic [MS_W-1:0]   ms;
        logic [CODE_W-1:0] code;
    } evt_fields_t;

endpackage

// File: rtl/mcb_arb.sv
module mcb_arb
    import mcb_pkg::*;
#(
    parameter int NP     = 4,
    parameter int ADDR_W = 48
) (
    input  logic [NP-1:0]        evt_vld,
    input  logic [NP-1:0]        evt_uc,
    input  logic [NP-1:0]        evt_spec,
    input  logic [NP-1:0]        evt_addr_ok,
    input  logic [NP*CODE_W-1:0] evt_code,
    input  logic [NP*MS_W-1:0]   evt_ms,
    input  logic [NP*ADDR_W-1:0] evt_addr,
    output logic                 win_vld,
    output logic                 multi,
    output evt_fields_t          win,
    output logic [ADDR_W-1:0]    win_addr
);

    localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1;
    localparam int CNT_W = $clog2(NP + 1);

    logic [NP-1:0]    eff;
    logic [IDX_W-1:0] sel;
    logic [IDX_W-1:0] uc_idx;
    logic [IDX_W-1:0] any_idx;
    logic             uc_hit;
    logic [CNT_W-1:0] n_eff;

    // a speculative correctable event is filtered out before arbitration
    for (genvar g = 0; g < NP; g++) begin : g_flt
        assign eff[g] = evt_vld[g] & (evt_uc[g] | ~evt_spec[g]);
    end

    always_comb begin
        uc_hit  = 1'b0;
        uc_idx  = '0;
        any_idx = '0;
        n_eff   = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (eff[i]) begin
                any_idx = IDX_W'(i);
                n_eff   = n_eff + CNT_W'(1);
            end
            if (eff[i] && evt_uc[i]) begin
                uc_hit = 1'b1;
                uc_idx = IDX_W'(i);
            end
        end
        sel = uc_hit ? uc_idx : any_idx;
    end

    always_comb begin
        win      = '0;
        win_addr = '0;
        for (int i = 0; i < NP; i++) begin
            if (sel == IDX_W'(i)) begin
                win.uc      = evt_uc[i];
                win.addr_ok = evt_addr_ok[i];
                win.code    = evt_code[i*CODE_W +: CODE_W];
                win.ms      = evt_ms[i*MS_W +: MS_W];
                win_addr    = evt_addr[i*ADDR_W +: ADDR_W];
            end
        end
    end

    assign win_vld = |eff;
    assign multi   = (n_eff > CNT_W'(1));

endmodule

// File: rtl/mcb_fsm.sv
module mcb_fsm
    import mcb_pkg::*;
#(
    parameter int CLR_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        win_vld,
    input  logic        win_uc,
    input  logic        multi,
    input  logic        sw_clr,
    output logic        load,
    output logic        ovf_set,
    output logic        wipe,
    output logic        mce_q,
    output bank_state_e state
);

    localparam int CW = $clog2(CLR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CLR_CYCLES - 1);

    bank_state_e nxt;
    bank_state_e base;
    logic [CW-1:0] cnt;

    always_comb begin
        base    = state;
        wipe    = 1'b0;
        load    = 1'b0;
        ovf_set = 1'b0;
        if (state != ST_CLEARING && sw_clr) begin
            wipe = 1'b1;
            base = ST_EMPTY;
        end
        nxt = base;
        unique case (base)
            ST_CLEARING: begin
                if (cnt == LAST) nxt = ST_EMPTY;
            end
            ST_EMPTY: begin
                if (win_vld) begin
                    load    = 1'b1;
                    ovf_set = multi;
                    nxt     = win_uc ? ST_HOLD_UC : ST_HOLD_CE;
                end
            end
            ST_HOLD_CE: begin
                if (win_vld) begin
                    load    = 1'b1;
                    ovf_set = 1'b1;
                    nxt     = win_uc ? ST_HOLD_UC : ST_HOLD_CE;
                end
            end
            ST_HOLD_UC: begin
                if (win_vld) ovf_set = 1'b1;
            end
            default: nxt = ST_CLEARING;
        endcase
    end

    // state register and clearing counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEARING;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_CLEARING) ? cnt + CW'(1) : '0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mce_q <= 1'b0;
        end else begin
            mce_q <= load & win_uc;
        end
    end

endmodule

// File: rtl/mcb_regs.sv
module mcb_regs
    import mcb_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                ovf_set,
    input  logic                wipe,
    input  evt_fields_t         win,
    input  logic [ADDR_W-1:0]   win_addr,
    output logic [STAT_W-1:0]   stat,
    output logic [ADDR_W-1:0]   addr
);

    logic              valid_q;
    logic              ovf_q;
    logic              uc_q;
    logic              av_q;
    logic [CODE_W-1:0] code_q;
    logic [MS_W-1:0]   ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
            uc_q    <= 1'b0;
            av_q    <= 1'b0;
            code_q  <= '0;
            ms_q    <= '0;
            addr    <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            ovf_q   <= (ovf_q & ~wipe) | ovf_set;
            uc_q    <= win.uc;
            av_q    <= win.addr_ok;
            code_q  <= win.code;
            ms_q    <= win.ms;
            if (win.addr_ok) addr <= win_addr;
            else if (wipe)   addr <= '0;
        end else if (wipe) begin
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
            uc_q    <= 1'b0;
            av_q    <= 1'b0;
            code_q  <= '0;
            ms_q    <= '0;
            addr    <= '0;
        end else if (ovf_set) begin
            ovf_q <= 1'b1;
        end
    end

    always_comb begin
        stat = '0;
        stat[B_VALID] = valid_q;
        stat[B_OVF]   = ovf_q;
        stat[B_UC]    = uc_q;
        stat[B_AV]    = av_q;
        stat[B_MS_LSB +: MS_W]     = ms_q;
        stat[B_CODE_LSB +: CODE_W] = code_q;
    end

endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
    import mcb_pkg::*;
#(
    parameter int NP         = 4,
    parameter int ADDR_W     = 48,
    parameter int CLR_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        evt_vld,
    input  logic [NP-1:0]        evt_uc,
    input  logic [NP-1:0]        evt_spec,
    input  logic [NP-1:0]        evt_addr_ok,
    input  logic [NP*16-1:0]     evt_code,
    input  logic [NP*16-1:0]     evt_ms,
    input  logic [NP*ADDR_W-1:0] evt_addr,
    input  logic                 sw_we,
    input  logic [63:0]          sw_wdata,
    output logic [63:0]          stat_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 mce_pulse_o
);

    logic              win_vld;
    logic              multi;
    evt_fields_t       win;
    logic [ADDR_W-1:0] win_addr;
    logic              load;
    logic              ovf_set;
    logic              wipe;
    logic              sw_clr;
    bank_state_e       state;

    assign sw_clr = sw_we && (sw_wdata == 64'h0);

    mcb_arb #(.NP(NP), .ADDR_W(ADDR_W)) u_arb (
        .evt_vld     (evt_vld),
        .evt_uc      (evt_uc),
        .evt_spec    (evt_spec),
        .evt_addr_ok (evt_addr_ok),
        .evt_code    (evt_code),
        .evt_ms      (evt_ms),
        .evt_addr    (evt_addr),
        .win_vld     (win_vld),
        .multi       (multi),
        .win         (win),
        .win_addr    (win_addr)
    );

    mcb_fsm #(.CLR_CYCLES(CLR_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_vld (win_vld),
        .win_uc  (win.uc),
        .multi   (multi),
        .sw_clr  (sw_clr),
        .load    (load),
        .ovf_set (ovf_set),
        .wipe    (wipe),
        .mce_q   (mce_pulse_o),
        .state   (state)
    );

    mcb_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ovf_set  (ovf_set),
        .wipe     (wipe),
        .win      (win),
        .win_addr (win_addr),
        .stat     (stat_o),
        .addr     (addr_o)
    );

endmodule

// File: rtl/mcb_bank_chk.sv
module mcb_bank_chk #(
    parameter int NP     = 4,
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NP-1:0]     evt_vld,
    input logic [NP-1:0]     evt_uc,
    input logic [NP-1:0]     evt_spec,
    input logic              sw_we,
    input logic [63:0]       sw_wdata,
    input logic [63:0]       stat_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              mce_pulse_o
);

    logic any_eff;
    logic spec_only;
    logic clr;

    assign any_eff   = |(evt_vld & (evt_uc | ~evt_spec));
    assign spec_only = |(evt_vld & evt_spec & ~evt_uc);
    assign clr       = sw_we && (sw_wdata == 64'h0);

    // R5
    ovf_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[63] && any_eff && !clr) |=> stat_o[62]);

    // R7
    uc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[61] && !clr) |=> ($stable({stat_o[63], stat_o[61:58], stat_o[31:0]}) && $stable(addr_o)));

    // R11
    mce_has_uc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mce_pulse_o |-> (stat_o[63] && stat_o[61]));

    // R3
    av_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[58] |-> stat_o[63]);

    // R10
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_eff) |=> (stat_o == 64'h0));

    // R4
    spec_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_only && !any_eff && !stat_o[63]) |=> (stat_o == 64'h0 && !mce_pulse_o));

endmodule

bind mcb_bank mcb_bank_chk #(.NP(NP), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_vld     (evt_vld),
    .evt_uc      (evt_uc),
    .evt_spec    (evt_spec),
    .sw_we       (sw_we),
    .sw_wdata    (sw_wdata),
    .stat_o      (stat_o),
    .addr_o      (addr_o),
    .mce_pulse_o (mce_pulse_o)
);

// File: tb/sim_mcb_bank.sv
module sim_mcb_bank;

    localparam int NP  = 3;
    localparam int AW  = 40;
    localparam int CLR = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    evt_vld = '0;
    logic [NP-1:0]    evt_uc = '0;
    logic [NP-1:0]    evt_spec = '0;
    logic [NP-1:0]    evt_addr_ok = '0;
    logic [NP*16-1:0] evt_code = '0;
    logic [NP*16-1:0] evt_ms = '0;
    logic [NP*AW-1:0] evt_addr = '0;
    logic             sw_we = 1'b0;
    logic [63:0]      sw_wdata = '0;
    logic [63:0]      stat_o;
    logic [AW-1:0]    addr_o;
    logic             mce_pulse_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mcb_bank #(.NP(NP), .ADDR_W(AW), .CLR_CYCLES(CLR)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_uc(evt_uc),
        .evt_spec(evt_spec), .evt_addr_ok(evt_addr_ok), .evt_code(evt_code),
        .evt_ms(evt_ms), .evt_addr(evt_addr), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .stat_o(stat_o), .addr_o(addr_o), .mce_pulse_o(mce_pulse_o)
    );

    function automatic logic [63:0] st(bit v, bit o, bit u, bit a,
                                       logic [15:0] ms, logic [15:0] code);
        return {v, o, u, 2'b00, a, 26'b0, ms, code};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ev(int p, bit uc, bit spec, bit aok,
                      logic [15:0] code, logic [15:0] ms, logic [AW-1:0] a);
        evt_vld[p]          = 1'b1;
        evt_uc[p]           = uc;
        evt_spec[p]         = spec;
        evt_addr_ok[p]      = aok;
        evt_code[p*16 +: 16] = code;
        evt_ms[p*16 +: 16]   = ms;
        evt_addr[p*AW +: AW] = a;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        evt_vld  = '0;
        evt_uc   = '0;
        evt_spec = '0;
        evt_addr_ok = '0;
        sw_we    = 1'b0;
        sw_wdata = '0;
    endtask

    task automatic sw_write(logic [63:0] d);
        sw_we = 1'b1;
        sw_wdata = d;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 status in reset", stat_o, 64'h0);
        chk("R1 addr in reset", {24'b0, addr_o}, 64'h0);
        rst_n = 1'b1;
        ev(0, 1, 0, 1, 16'h00EE, 16'h0011, 40'h55);
        step();
        chk("R1 event during clearing ignored", stat_o, 64'h0);
        chk("R1 no pulse during clearing", {63'b0, mce_pulse_o}, 64'h0);
        sw_write(64'h0);
        repeat (CLR) step();
        chk("R1 empty after clearing", stat_o, 64'h0);
    endtask

    task automatic t_first_ce();
        ev(1, 0, 0, 1, 16'h1234, 16'hABCD, 40'h12_3456_7890);
        step();
        chk("R2 first correctable capture", stat_o, st(1, 0, 0, 1, 16'hABCD, 16'h1234));
        chk("R3 address captured", {24'b0, addr_o}, 64'h12_3456_7890);
        chk("R11 no pulse for correctable", {63'b0, mce_pulse_o}, 64'h0);
    endtask

    task automatic t_ce_overwrite();
        ev(0, 0, 0, 0, 16'h0055, 16'h0066, 40'hFF_FFFF);
        step();
        chk("R6 correctable overwrite with overflow", stat_o, st(1, 1, 0, 0, 16'h0066, 16'h0055));
        chk("R3 address kept when not valid", {24'b0, addr_o}, 64'h12_3456_7890);
    endtask

    task automatic t_sw_clear();
        sw_write(64'h0000_0000_0000_00FF);
        chk("R10 nonzero write ignored", stat_o, st(1, 1, 0, 0, 16'h0066, 16'h0055));
        sw_write(64'h0);
        chk("R10 zero write clears status", stat_o, 64'h0);
        chk("R10 zero write clears addr", {24'b0, addr_o}, 64'h0);
    endtask

    task automatic t_spec();
        ev(2, 0, 1, 1, 16'h0777, 16'h0888, 40'h99);
        step();
        chk("R4 speculative correctable ignored in empty bank", stat_o, 64'h0);
        ev(0, 0, 0, 1, 16'h0101, 16'h0202, 40'h303);
        step();
        ev(1, 0, 1, 0, 16'h0F0F, 16'h0E0E, 40'h0);
        step();
        chk("R4 speculative correctable sets no overflow", stat_o, st(1, 0, 0, 1, 16'h0202, 16'h0101));
        sw_write(64'h0);
    endtask

    task automatic t_uc_freeze();
        ev(2, 1, 0, 1, 16'h0BAD, 16'h0001, 40'hAB_CDEF);
        step();
        chk("R2 uncorrectable capture", stat_o, st(1, 0, 1, 1, 16'h0001, 16'h0BAD));
        chk("R11 pulse on accepted uncorrectable", {63'b0, mce_pulse_o}, 64'h1);
        step();
        chk("R11 pulse lasts one cycle", {63'b0, mce_pulse_o}, 64'h0);
        ev(0, 0, 0, 1, 16'h0C0C, 16'h0D0D, 40'h11);
        step();
        chk("R8 correctable does not replace uncorrectable", stat_o, st(1, 1, 1, 1, 16'h0001, 16'h0BAD));
        ev(1, 1, 0, 0, 16'h0999, 16'h0AAA, 40'h22);
        step();
        chk("R7 later uncorrectable changes no field", stat_o, st(1, 1, 1, 1, 16'h0001, 16'h0BAD));
        chk("R7 address frozen", {24'b0, addr_o}, 64'hAB_CDEF);
        chk("R11 no pulse when blocked", {63'b0, mce_pulse_o}, 64'h0);
    endtask

    task automatic t_clear_and_event();
        sw_we = 1'b1;
        sw_wdata = 64'h0;
        ev(1, 0, 0, 1, 16'h0007, 16'h0002, 40'h4444);
        step();
        chk("R12 clear plus event logs into empty bank", stat_o, st(1, 0, 0, 1, 16'h0002, 16'h0007));
        chk("R12 address from new event", {24'b0, addr_o}, 64'h4444);
    endtask

    task automatic t_ce_then_uc();
        ev(2, 1, 0, 0, 16'h0E01, 16'h0E02, 40'h0);
        step();
        chk("R8 uncorrectable replaces correctable", stat_o, st(1, 1, 1, 0, 16'h0E02, 16'h0E01));
        chk("R5 overflow with correctable held", {63'b0, stat_o[62]}, 64'h1);
        chk("R11 pulse on replacing uncorrectable", {63'b0, mce_pulse_o}, 64'h1);
        sw_write(64'h0);
    endtask

    task automatic t_priority();
        ev(0, 0, 0, 1, 16'h0A00, 16'h0B00, 40'h1);
        ev(2, 1, 0, 1, 16'h0A02, 16'h0B02, 40'h3);
        step();
        chk("R9 uncorrectable wins over lower index", stat_o, st(1, 1, 1, 1, 16'h0B02, 16'h0A02));
        sw_write(64'h0);
        ev(1, 0, 0, 1, 16'h0C01, 16'h0D01, 40'h2);
        ev(2, 0, 0, 1, 16'h0C02, 16'h0D02, 40'h3);
        step();
        chk("R9 lowest index wins among correctable", stat_o, st(1, 1, 0, 1, 16'h0D01, 16'h0C01));
        chk("R9 winner address", {24'b0, addr_o}, 64'h2);
        sw_write(64'h0);
        ev(0, 0, 1, 1, 16'h0F00, 16'h0F10, 40'h7);
        ev(2, 0, 0, 0, 16'h0F02, 16'h0F12, 40'h8);
        step();
        chk("R9 R4 speculative neither wins nor overflows", stat_o, st(1, 0, 0, 0, 16'h0F12, 16'h0F02));
        sw_write(64'h0);
    endtask

    task automatic t_reset_glitch();
        ev(0, 1, 0, 1, 16'h0123, 16'h0456, 40'h789);
        step();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            ev(1, 0, 0, 1, 16'h0AAA, 16'h0BBB, 40'h5);
            step();
        end
        chk("R1 re-pulsed reset keeps bank cleared", stat_o, 64'h0);
        repeat (CLR) step();
        chk("R1 empty after restarted clearing", stat_o, 64'h0);
        ev(1, 0, 0, 1, 16'h0AAA, 16'h0BBB, 40'h5);
        step();
        chk("R1 R2 logging works after restart", stat_o, st(1, 0, 0, 1, 16'h0BBB, 16'h0AAA));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_ce();
        t_ce_overwrite();
        t_sw_clear();
        t_spec();
        t_uc_freeze();
        t_clear_and_event();
        t_ce_then_uc();
        t_priority();
        t_reset_glitch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule